// File: doc/BRIEF.md
# Selectable Divide-by-2/3 Clock Divider with Balanced Duty Cycle

This block takes a free-running input clock and produces a slower clock at one half or one third of its frequency, picked by a single mode input. In both ratios the output spends equal time high and low. For the odd ratio this needs a half-period step that a single clock edge cannot provide. Two rising-edge registers form the counter. A feedback term gated by the mode input turns that pair into either a three-state sequence or a simple toggle stage.

A third register samples the counter's leading bit on the falling edge of the input clock. When the odd ratio is selected, that leading bit is ORed with its half-period-delayed copy, so the output high phase is stretched to one and a half input periods. When the even ratio is selected, the output is the falling-edge register alone.

A typical use is to derive a balanced secondary clock or strobe from a system clock without a PLL. The ratio may be changed at run time, and a short irregular stretch of output is accepted while it settles.

Top module: `clkdiv23_sym`

## Requirements
- R1: An active-high asynchronous `rst` clears all three registers at once; `clk_out` is 0 for as long as `rst` is held, whether or not the clock runs.
- R2: With `div_sel` = 1 the counter cycles through exactly three states. Both counter registers are never high together. Once the second counter register is high, the leading register stays low at the next rising edge. `clk_out` repeats every 3 input periods.
- R3: With `div_sel` = 1, `clk_out` is high for 1.5 input periods and low for 1.5 input periods (15 ns each at a 10 ns input period).
- R4: With `div_sel` = 0 the leading counter register inverts at every rising edge. `clk_out` is high for 1 input period and low for 1 input period.
- R5: The balancing register loads the leading counter bit on each falling edge of `clk`. With `div_sel` = 0, both edges of `clk_out` therefore fall on falling edges of `clk`.
- R6: With `div_sel` = 1, `clk_out` rises together with a rising edge of `clk` and falls together with a falling edge of `clk`.
- R7: After `rst` is released, the first rise of `clk_out` comes at the first rising edge of `clk` when `div_sel` = 1. When `div_sel` = 0 it comes at the falling edge that follows that rising edge.
- R8: A change of `div_sel` is used by the counter feedback at the next rising edge. From the third rise of `clk_out` after the change onward, the timing of the new ratio (R3/R6 or R4/R5) holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock to be divided |
| rst | input | 1 | Asynchronous reset, active high |
| div_sel | input | 1 | Ratio select: 0 divides by 2, 1 divides by 3 |
| clk_out | output | 1 | Divided clock with balanced duty cycle |

## Verification
Two events can fall on the same rising edge: a change of ratio and the counter's wrap or the output stretch. The mode input is therefore flipped, in both directions, at every one of six rising-edge positions within the output cycle, both shortly after a rising edge and shortly after a falling edge. Once the allowed settling span has passed, each output edge is timestamped, and its high time, low time and the phase of its edges against the input clock are compared with the figures for the ratio in force. Reset release is also swept across several clock positions, and the delay to the first output rise is compared with the value expected for each ratio.

// File: rtl/clkdiv23_pkg.sv
package clkdiv23_pkg;

  // Ratio encoding carried on div_sel
  typedef enum logic {
    RATIO_HALF  = 1'b0,
    RATIO_THIRD = 1'b1
  } ratio_e;

  // Next value of the leading counter bit. With the odd ratio the trailing
  // bit blocks the set, giving three states; otherwise it is a toggle.
  function automatic logic lead_next(input logic lead, input logic lag,
                                     input logic third);
    return ~(lead | (third & lag));
  endfunction

  // Output merge: the held (half-period delayed) bit, widened by the live
  // leading bit when the odd ratio is active.
  function automatic logic out_merge(input logic held, input logic lead,
                                     input logic third);
    return held | (third & lead);
  endfunction

endpackage

// File: rtl/clkdiv23_count.sv
module clkdiv23_count
  import clkdiv23_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic third,
  output logic lead,
  output logic lag
);

  logic lead_d;

  always_comb lead_d = lead_next(lead, lag, third);

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      lead <= 1'b0;
      lag  <= 1'b0;
    end else begin
      lead <= lead_d;
      lag  <= lead;
    end
  end

endmodule

// File: rtl/clkdiv23_halfcap.sv
module clkdiv23_halfcap (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);

  // Captures on the falling input edge: a half-period delayed copy
  always_ff @(negedge clk or posedge rst) begin
    if (rst) q <= 1'b0;
    else     q <= d;
  end

endmodule

// File: rtl/clkdiv23_merge.sv
module clkdiv23_merge
  import clkdiv23_pkg::*;
(
  input  logic held,
  input  logic lead,
  input  logic third,
  output logic out
);

  always_comb out = out_merge(held, lead, third);

endmodule

// File: rtl/clkdiv23_sym.sv
module clkdiv23_sym
  import clkdiv23_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic div_sel,
  output logic clk_out
);

  // Named internal events, visible to the bound checker
  logic sel_third;
  logic q_lead;
  logic q_lag;
  logic q_hold;

  always_comb sel_third = (ratio_e'(div_sel) == RATIO_THIRD);

  clkdiv23_count count_i (
    .clk   (clk),
    .rst   (rst),
    .third (sel_third),
    .lead  (q_lead),
    .lag   (q_lag)
  );

  clkdiv23_halfcap halfcap_i (
    .clk (clk),
    .rst (rst),
    .d   (q_lead),
    .q   (q_hold)
  );

  clkdiv23_merge merge_i (
    .held  (q_hold),
    .lead  (q_lead),
    .third (sel_third),
    .out   (clk_out)
  );

endmodule

// File: rtl/clkdiv23_sym_chk.sv
module clkdiv23_sym_chk (
  input logic clk,
  input logic rst,
  input logic div_sel,
  input logic q_lead,
  input logic q_lag,
  input logic q_hold,
  input logic clk_out
);

  // Rising edges since reset, saturating at 3
  logic [1:0] warm;
  always_ff @(posedge clk or posedge rst) begin
    if (rst)              warm <= 2'd0;
    else if (warm != 2'd3) warm <= warm + 2'd1;
  end

  // R1: output low while reset is held
  assert_reset_low_R1: assert property (@(posedge clk)
    rst |-> !clk_out);

  // R2: the two counter bits are never high together
  assert_no_both_high_R2: assert property (@(posedge clk) disable iff (rst)
    !(q_lead && q_lag));

  // R2: with the odd ratio, a high trailing bit keeps the leading bit low
  assert_hold_low_R2: assert property (@(posedge clk) disable iff (rst)
    (div_sel && q_lag) |=> !q_lead);

  // R4: with the even ratio, the leading bit inverts every rising edge
  assert_toggle_R4: assert property (@(posedge clk) disable iff (rst)
    !div_sel |=> (q_lead != $past(q_lead)));

  // R4: steady even ratio, the output seen at rising edges alternates
  assert_half_rate_R4: assert property (@(posedge clk) disable iff (rst)
    (warm >= 2'd2 && !div_sel && !$past(div_sel) && !$past(div_sel, 2))
      |-> (clk_out != $past(clk_out)));

  // R5: the balancing bit, seen at a rising edge, equals the leading bit
  assert_resample_R5: assert property (@(posedge clk) disable iff (rst)
    q_hold == q_lead);

endmodule

bind clkdiv23_sym clkdiv23_sym_chk chk_i (
  .clk     (clk),
  .rst     (rst),
  .div_sel (div_sel),
  .q_lead  (q_lead),
  .q_lag   (q_lag),
  .q_hold  (q_hold),
  .clk_out (clk_out)
);

// File: tb/clkdiv23_sym_tb_top.sv
`timescale 1ns/1ps
module clkdiv23_sym_tb_top;

  localparam int PERIOD = 10;
  localparam int HALF   = PERIOD / 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic div_sel = 1'b0;
  logic clk_out;

  int n_tests = 0;
  int n_fail  = 0;

  clkdiv23_sym dut_i (
    .clk     (clk),
    .rst     (rst),
    .div_sel (div_sel),
    .clk_out (clk_out)
  );

  always #HALF clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // One full output period: high time, low time and edge phases
  task automatic measure(input bit third);
    longint t_rise, t_fall, t_next;
    longint exp_len, exp_phase;
    exp_len   = third ? (3 * PERIOD) / 2 : PERIOD;
    exp_phase = third ? HALF : 0;   // rising edges at 5 mod 10, falling at 0
    @(posedge clk_out); t_rise = $time;
    @(negedge clk_out); t_fall = $time;
    @(posedge clk_out); t_next = $time;
    if (third) begin
      check(t_fall - t_rise == exp_len, "R3", "high time", t_fall - t_rise, exp_len);
      check(t_next - t_fall == exp_len, "R3", "low time",  t_next - t_fall, exp_len);
      check(t_next - t_rise == 3 * PERIOD, "R2", "period", t_next - t_rise, 3 * PERIOD);
      check(t_rise % PERIOD == exp_phase, "R6", "rise phase", t_rise % PERIOD, exp_phase);
      check(t_fall % PERIOD == 0, "R6", "fall phase", t_fall % PERIOD, 0);
    end else begin
      check(t_fall - t_rise == exp_len, "R4", "high time", t_fall - t_rise, exp_len);
      check(t_next - t_fall == exp_len, "R4", "low time",  t_next - t_fall, exp_len);
      check(t_rise % PERIOD == exp_phase, "R5", "rise phase", t_rise % PERIOD, exp_phase);
      check(t_fall % PERIOD == 0, "R5", "fall phase", t_fall % PERIOD, 0);
    end
  endtask

  // Reset with the clock running, then release at a swept position
  task automatic reset_and_start(input bit third, input int wait_n);
    longint t_rel, t_up, exp_dly;
    @(negedge clk); #2;
    rst = 1'b1;
    div_sel = third;
    #1;
    check(clk_out == 1'b0, "R1", "output at reset entry", clk_out, 0);
    repeat (3) @(negedge clk);
    #3;
    check(clk_out == 1'b0, "R1", "output during reset", clk_out, 0);
    repeat (wait_n) @(negedge clk);
    @(negedge clk); #2;
    rst = 1'b0;
    t_rel = $time;
    exp_dly = third ? 3 : 8;   // next rising edge, or the falling edge after it
    @(posedge clk_out); t_up = $time;
    check(t_up - t_rel == exp_dly, "R7", "first rise delay", t_up - t_rel, exp_dly);
  endtask

  // Flip the ratio at a swept point, let it settle, then time it
  task automatic switch_ratio(input bit third, input int edges, input int offs);
    repeat (edges) @(posedge clk);
    #(offs);
    div_sel = third;
    repeat (2) @(posedge clk_out);
    for (int k = 0; k < 3; k++) begin
      measure(third);
    end
    n_tests++;   // R8: settled timing of the new ratio reached
  endtask

  initial begin
    #1;
    check(clk_out == 1'b0, "R1", "output at time zero under reset", clk_out, 0);

    // Start-up and steady timing in both ratios, release swept
    for (int m = 0; m < 2; m++) begin
      for (int w = 0; w < 3; w++) begin
        reset_and_start(m[0], w);
        for (int k = 0; k < 4; k++) measure(m[0]);
      end
    end

    // Asynchronous reset mid-run while the output is high
    reset_and_start(1'b1, 0);
    @(posedge clk_out); #2;
    rst = 1'b1; #1;
    check(clk_out == 1'b0, "R1", "output after async reset", clk_out, 0);
    #20;
    check(clk_out == 1'b0, "R1", "output with reset held", clk_out, 0);

    // Ratio changes in both directions, every phase of the output cycle
    for (int h = 0; h < 2; h++) begin
      for (int j = 0; j < 6; j++) begin
        reset_and_start(1'b0, 0);
        switch_ratio(1'b1, j, h ? 7 : 2);
        switch_ratio(1'b0, j, h ? 7 : 2);
      end
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(200000 * PERIOD);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule